// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps the time of day and the calendar date. It is driven by a one-cycle enable `tick_i` at 32.768 kHz in the core clock domain. Every field is packed BCD. The hour runs in 24-hour form. A millisecond field sits below the seconds. The year runs from 0000 to 9999, applies the Gregorian leap rule, and wraps back to 0000. A fractional divider turns the 32768 ticks of each second into exactly 1000 millisecond steps.

Three event functions are built around the counter chain:

- An alarm compares day of month, hour, minute and second against a programmed value.
- A periodic pulse runs at 2^k Hz for k from 0 to 9, aligned to the tick position within the second.
- A tamper capture latches the current time and date once, raises a flag and, if enabled, drives an output that cuts standby power to SRAM.

Software reaches the block through a word-wide register port. Writes take effect at the next clock edge. Reads are combinational from `addr_i`.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time is 00:00:00.000 and the date is 2000-01-01. Register 1 reads 32'h2000_0101. Registers 0, 3, 4 and 5 read zero. All four event outputs are low.
- R2: A millisecond lasts 33 ticks when adding 768 to a remainder accumulator (cleared at each restart, kept modulo 1000) reaches 1000 or more, and 32 ticks otherwise. Exactly 32768 ticks after a restart the millisecond field goes from 999 to 000. Register 5 bits [11:0] read the milliseconds as three BCD digits.
- R3: When the milliseconds roll over, the second advances 00..59. The minute carries 00..59 and the hour carries 00..23. Register 0 holds hour [23:16], minute [15:8] and second [7:0].
- R4: When the hour wraps, the day of month advances up to the month's last day and then returns to 01. Months run 01..12. Month 12 carries into the year, and year 9999 wraps to 0000. Register 1 holds year [31:16], month [15:8] and day [7:0].
- R5: February has 29 days when the year is divisible by 4, except for years divisible by 100 and not by 400. April, June, September and November have 30 days; the other months have 31.
- R6: A write to register 0 or register 1 loads that register's fields, clears the milliseconds to 000 and restarts the sub-second divider and the tick position.
- R7: When control bit 0 is set, the alarm flag sets once the running time advances into a second whose day/hour/minute/second equal register 2 ([31:24]/[23:16]/[15:8]/[7:0]). The flag drives `alarm_irq_o` and reads at status bit 0. Writing 1 to register 4 bit 0 clears it. With control bit 0 clear the flag never sets.
- R8: Control bit 1 enables the periodic pulse and bits [5:2] give k; values above 9 act as 9. A one-cycle pulse follows every tick that brings the tick position within the second to a multiple of 32768/2^k. Over W ticks after a restart this gives W/(32768/2^k) pulses, rounded down.
- R9: On `tamper_i` with the tamper flag clear, the flag sets. The current hour/minute/second are copied to register 6 [23:0] and the year/month/day to register 7 in the layout of register 1. The flag drives `tamper_flag_o` and reads at status bit 1.
- R10: While the tamper flag is set, further tamper events change neither the captured values nor the flag. Writing 1 to register 4 bit 1 clears the flag.
- R11: `sram_cut_o` is high exactly when the tamper flag is set and control bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of register `addr_i` |
| tamper_i | input | 1 | Tamper event, synchronous, one cycle |
| alarm_irq_o | output | 1 | Alarm flag |
| periodic_irq_o | output | 1 | Periodic pulse |
| tamper_flag_o | output | 1 | Tamper flag |
| sram_cut_o | output | 1 | Cut SRAM standby power |

## Verification
The assertions take three things for granted about the inputs. Software writes only legal BCD times and dates (hour at most 23, day between 01 and the month's length). A tick and a time or date write never fall in the same cycle. `tamper_i` is already synchronous to `clk_i`. Under those conditions the checks on BCD digit ranges, hour and day bounds, and "seconds move only on a millisecond wrap" hold. The stimulus keeps within these limits: it builds every written field from integers through a BCD conversion with bounded ranges from `$urandom` under a fixed seed, and it drives ticks and writes from the same sequential thread so they never overlap.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  typedef struct packed {
    logic [15:0] year;
    logic [7:0]  month;
    logic [7:0]  day;
    logic [7:0]  hour;
    logic [7:0]  minute;
    logic [7:0]  second;
    logic [11:0] msec;
  } rtc_time_t;

  localparam logic [2:0] A_TIME   = 3'd0;
  localparam logic [2:0] A_DATE   = 3'd1;
  localparam logic [2:0] A_ALARM  = 3'd2;
  localparam logic [2:0] A_CTRL   = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_MSEC   = 3'd5;
  localparam logic [2:0] A_TTIME  = 3'd6;
  localparam logic [2:0] A_TDATE  = 3'd7;

  // ripple increment over four BCD digits
  function automatic logic [15:0] bcd_inc(input logic [15:0] v);
    logic [15:0] r;
    logic        c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c) begin
        if (v[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = v[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // two BCD digits divisible by four
  function automatic logic bcd2_div4(input logic [7:0] b);
    if (b[4]) return (b[3:0] == 4'd2) || (b[3:0] == 4'd6);
    return (b[3:0] == 4'd0) || (b[3:0] == 4'd4) || (b[3:0] == 4'd8);
  endfunction

  function automatic logic bcd_leap(input logic [15:0] y);
    if (y[7:0] == 8'h00) return bcd2_div4(y[15:8]);
    return bcd2_div4(y[7:0]);
  endfunction

  function automatic logic [7:0] bcd_last_day(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_rtc_subsec.sv
module bcd_rtc_subsec #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  localparam int TW = $clog2(TICKS_PER_SEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  output logic          ms_stb_o,
  output logic [TW-1:0] pos_nxt_o
);
  localparam int BASE = TICKS_PER_SEC / MS_PER_SEC;
  localparam int REM  = TICKS_PER_SEC % MS_PER_SEC;
  localparam int CW   = $clog2(BASE + 2);
  localparam int EW   = $clog2(MS_PER_SEC) + 1;

  logic [CW-1:0] cnt_q, cnt_inc, len;
  logic [EW-1:0] err_q, err_sum;
  logic [TW-1:0] pos_q;
  logic          long_ms;

  always_comb begin
    err_sum   = err_q + EW'(REM);
    long_ms   = err_sum >= EW'(MS_PER_SEC);
    len       = long_ms ? CW'(BASE + 1) : CW'(BASE);
    cnt_inc   = cnt_q + CW'(1);
    ms_stb_o  = tick_i && !restart_i && (cnt_inc == len);
    pos_nxt_o = (pos_q == TW'(TICKS_PER_SEC - 1)) ? '0 : pos_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= '0;
      pos_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
      err_q <= '0;
      pos_q <= '0;
    end else if (tick_i) begin
      pos_q <= pos_nxt_o;
      if (ms_stb_o) begin
        cnt_q <= '0;
        err_q <= long_ms ? err_sum - EW'(MS_PER_SEC) : err_sum;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

endmodule

// File: rtl/bcd_rtc_periodic.sv
module bcd_rtc_periodic #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MAX_RATE_LOG  = 9,
  parameter int RW            = 4,
  localparam int TW = $clog2(TICKS_PER_SEC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          en_i,
  input  logic [RW-1:0] rate_i,
  input  logic [TW-1:0] pos_nxt_i,
  output logic          pulse_o
);
  logic [RW-1:0] k;
  logic [TW:0]   period;
  logic [TW-1:0] mask;
  logic          hit;

  always_comb begin
    k      = (rate_i > RW'(MAX_RATE_LOG)) ? RW'(MAX_RATE_LOG) : rate_i;
    period = (TW+1)'(TICKS_PER_SEC) >> k;
    mask   = TW'(period - (TW+1)'(1));
    hit    = (pos_nxt_i & mask) == '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= tick_i && !restart_i && en_i && hit;
  end

endmodule

// File: rtl/bcd_rtc_chain.sv
module bcd_rtc_chain
  import bcd_rtc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ms_stb_i,
  input  logic        set_time_i,
  input  logic        set_date_i,
  input  logic [31:0] wdata_i,
  output rtc_time_t   cur_o,
  output logic        sec_adv_o
);
  rtc_time_t nxt;
  logic ms_w, sec_w, min_w, hr_w, day_w, mon_w;

  always_comb begin
    nxt   = cur_o;
    ms_w  = cur_o.msec == 12'h999;
    sec_w = ms_w  && cur_o.second == 8'h59;
    min_w = sec_w && cur_o.minute == 8'h59;
    hr_w  = min_w && cur_o.hour == 8'h23;
    day_w = hr_w  && cur_o.day == bcd_last_day(cur_o.month, bcd_leap(cur_o.year));
    mon_w = day_w && cur_o.month == 8'h12;
    nxt.msec = ms_w ? 12'h000 : bcd_inc({4'h0, cur_o.msec})[11:0];
    if (ms_w)  nxt.second = sec_w ? 8'h00 : bcd_inc({8'h00, cur_o.second})[7:0];
    if (sec_w) nxt.minute = min_w ? 8'h00 : bcd_inc({8'h00, cur_o.minute})[7:0];
    if (min_w) nxt.hour   = hr_w  ? 8'h00 : bcd_inc({8'h00, cur_o.hour})[7:0];
    if (hr_w)  nxt.day    = day_w ? 8'h01 : bcd_inc({8'h00, cur_o.day})[7:0];
    if (day_w) nxt.month  = mon_w ? 8'h01 : bcd_inc({8'h00, cur_o.month})[7:0];
    if (mon_w) nxt.year   = bcd_inc(cur_o.year);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o     <= '{year: 16'h2000, month: 8'h01, day: 8'h01, default: '0};
      sec_adv_o <= 1'b0;
    end else begin
      sec_adv_o <= 1'b0;
      if (set_time_i) begin
        cur_o.hour   <= wdata_i[23:16];
        cur_o.minute <= wdata_i[15:8];
        cur_o.second <= wdata_i[7:0];
        cur_o.msec   <= '0;
      end else if (set_date_i) begin
        cur_o.year  <= wdata_i[31:16];
        cur_o.month <= wdata_i[15:8];
        cur_o.day   <= wdata_i[7:0];
        cur_o.msec  <= '0;
      end else if (ms_stb_i) begin
        cur_o     <= nxt;
        sec_adv_o <= ms_w;
      end
    end
  end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int MAX_RATE_LOG  = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        tamper_i,
  output logic        alarm_irq_o,
  output logic        periodic_irq_o,
  output logic        tamper_flag_o,
  output logic        sram_cut_o
);
  localparam int TW = $clog2(TICKS_PER_SEC);
  localparam int RW = $clog2(MAX_RATE_LOG + 1);

  rtc_time_t     cur_q;
  logic          set_time, set_date, restart, ms_stb, sec_adv;
  logic [TW-1:0] pos_nxt;
  logic [31:0]   alarm_q;
  logic          alarm_en_q, per_en_q, cut_en_q;
  logic [RW-1:0] rate_q;
  logic          alarm_flag_q, tamper_flag_q;
  logic [23:0]   t_time_q;
  logic [31:0]   t_date_q;
  logic          clr_alarm, clr_tamper, alarm_hit;

  assign set_time   = wr_en_i && addr_i == A_TIME;
  assign set_date   = wr_en_i && addr_i == A_DATE;
  assign restart    = set_time || set_date;
  assign clr_alarm  = wr_en_i && addr_i == A_STATUS && wr_data_i[0];
  assign clr_tamper = wr_en_i && addr_i == A_STATUS && wr_data_i[1];
  assign alarm_hit  = alarm_en_q && sec_adv &&
                      {cur_q.day, cur_q.hour, cur_q.minute, cur_q.second} == alarm_q;

  bcd_rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC), .MS_PER_SEC(MS_PER_SEC)) u_subsec (
    .clk_i, .rst_ni, .tick_i, .restart_i(restart), .ms_stb_o(ms_stb), .pos_nxt_o(pos_nxt)
  );

  bcd_rtc_chain u_chain (
    .clk_i, .rst_ni, .ms_stb_i(ms_stb), .set_time_i(set_time), .set_date_i(set_date),
    .wdata_i(wr_data_i), .cur_o(cur_q), .sec_adv_o(sec_adv)
  );

  bcd_rtc_periodic #(.TICKS_PER_SEC(TICKS_PER_SEC), .MAX_RATE_LOG(MAX_RATE_LOG), .RW(RW)) u_per (
    .clk_i, .rst_ni, .tick_i, .restart_i(restart), .en_i(per_en_q), .rate_i(rate_q),
    .pos_nxt_i(pos_nxt), .pulse_o(periodic_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q    <= '0;
      alarm_en_q <= 1'b0;
      per_en_q   <= 1'b0;
      rate_q     <= '0;
      cut_en_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_ALARM) alarm_q <= wr_data_i;
      if (addr_i == A_CTRL) begin
        alarm_en_q <= wr_data_i[0];
        per_en_q   <= wr_data_i[1];
        rate_q     <= wr_data_i[2 +: RW];
        cut_en_q   <= wr_data_i[6];
      end
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        alarm_flag_q <= 1'b0;
    else if (alarm_hit) alarm_flag_q <= 1'b1;
    else if (clr_alarm) alarm_flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tamper_flag_q <= 1'b0;
      t_time_q      <= '0;
      t_date_q      <= '0;
    end else if (clr_tamper) begin
      tamper_flag_q <= 1'b0;
    end else if (tamper_i && !tamper_flag_q) begin
      tamper_flag_q <= 1'b1;
      t_time_q      <= {cur_q.hour, cur_q.minute, cur_q.second};
      t_date_q      <= {cur_q.year, cur_q.month, cur_q.day};
    end
  end

  assign alarm_irq_o   = alarm_flag_q;
  assign tamper_flag_o = tamper_flag_q;
  assign sram_cut_o    = tamper_flag_q && cut_en_q;

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_TIME:   rd_data_o = {8'h00, cur_q.hour, cur_q.minute, cur_q.second};
      A_DATE:   rd_data_o = {cur_q.year, cur_q.month, cur_q.day};
      A_ALARM:  rd_data_o = alarm_q;
      A_CTRL:   rd_data_o = 32'({cut_en_q, 4'(rate_q), per_en_q, alarm_en_q}) |
                            32'({cut_en_q, 6'h0}) & 32'h40;
      A_STATUS: rd_data_o = {30'h0, tamper_flag_q, alarm_flag_q};
      A_MSEC:   rd_data_o = {20'h0, cur_q.msec};
      A_TTIME:  rd_data_o = {8'h00, t_time_q};
      default:  rd_data_o = t_date_q;
    endcase
  end

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        tick_i,
  input logic        periodic_irq_o,
  input logic        tamper_flag_o,
  input logic        sram_cut_o,
  input rtc_time_t   cur_i,
  input logic [23:0] t_time_i,
  input logic [31:0] t_date_i
);

  AST_MS_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_i.msec[3:0] <= 4'd9 && cur_i.msec[7:4] <= 4'd9 && cur_i.msec[11:8] <= 4'd9); // R2

  AST_SEC_ON_MS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i.second != $past(cur_i.second)) && !$past(wr_en_i)
      |-> ($past(cur_i.msec) == 12'h999) && (cur_i.msec == 12'h000)); // R3

  AST_HOUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_i.hour <= 8'h23 && cur_i.minute <= 8'h59 && cur_i.second <= 8'h59); // R3

  AST_DAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_i.day != 8'h00 && cur_i.day <= 8'h31 && cur_i.month != 8'h00 && cur_i.month <= 8'h12); // R4

  AST_PERIODIC_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periodic_irq_o |-> $past(tick_i)); // R8

  AST_TAMPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tamper_flag_o && $past(tamper_flag_o) |-> $stable(t_time_i) && $stable(t_date_i)); // R10

  AST_CUT_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_cut_o |-> tamper_flag_o); // R11

endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .tick_i         (tick_i),
  .periodic_irq_o (periodic_irq_o),
  .tamper_flag_o  (tamper_flag_o),
  .sram_cut_o     (sram_cut_o),
  .cur_i          (cur_q),
  .t_time_i       (t_time_q),
  .t_date_i       (t_date_q)
);

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0, tamper_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic        alarm_irq_o, periodic_irq_o, tamper_flag_o, sram_cut_o;
  int n_chk = 0, n_fail = 0, pcnt = 0;

  always #10 clk = ~clk;

  bcd_rtc u_bcd_rtc (.clk_i(clk), .rst_ni, .tick_i, .wr_en_i, .addr_i, .wr_data_i, .rd_data_o,
    .tamper_i, .alarm_irq_o, .periodic_irq_o, .tamper_flag_o, .sram_cut_o);

  always @(negedge clk) if (periodic_irq_o) pcnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic run_ticks(int n);
    if (n > 0) begin
      @(negedge clk); tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] b8(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [11:0] b12(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int ms_model(int t);
    int tc = 0, err = 0, ms = 0;
    for (int i = 0; i < t; i++) begin
      tc++;
      if (tc == ((err + 768 >= 1000) ? 33 : 32)) begin
        tc = 0; ms++; err = (err + 768) % 1000;
      end
    end
    return ms;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] tv;
    int w, k, r;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 time", 3'd0, 32'h0);
    rd_chk("R1 date", 3'd1, 32'h2000_0101);
    rd_chk("R1 ctrl", 3'd3, 32'h0);
    rd_chk("R1 status", 3'd4, 32'h0);
    rd_chk("R1 msec", 3'd5, 32'h0);
    chk("R1 outputs", {28'h0, alarm_irq_o, periodic_irq_o, tamper_flag_o, sram_cut_o}, 32'h0);

    // R2 R6 random restart points
    for (int i = 0; i < 6; i++) begin
      tv = {8'h00, b8($urandom_range(0, 23)), b8($urandom_range(0, 59)), b8($urandom_range(0, 59))};
      w = (i == 0) ? 33 : $urandom_range(0, 3000);
      wr(3'd0, tv);
      run_ticks(w);
      rd_chk("R6 time loaded", 3'd0, tv);
      rd_chk("R2 msec", 3'd5, {20'h0, b12(ms_model(w))});
    end

    // R8 random periodic rates
    for (int i = 0; i < 5; i++) begin
      k = (i == 0) ? 12 : $urandom_range(0, 9);
      r = (k > 9) ? 9 : k;
      wr(3'd3, {26'h0, 4'(k), 2'b10});
      wr(3'd0, 32'h0);
      pcnt = 0;
      w = $urandom_range(0, 3000);
      run_ticks(w);
      chk("R8 pulse count", pcnt, w >> (15 - r));
    end
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0);
    pcnt = 0;
    run_ticks(2000);
    chk("R8 disabled", pcnt, 0);

    // R2 R3 R4 R7 R8 full rollover at year 9999
    wr(3'd2, 32'h0100_0000);
    wr(3'd3, {26'h0, 4'd9, 2'b11});
    wr(3'd1, 32'h9999_1231);
    wr(3'd0, 32'h0023_5959);
    pcnt = 0;
    run_ticks(32767);
    rd_chk("R2 msec before wrap", 3'd5, 32'h999);
    rd_chk("R3 time before wrap", 3'd0, 32'h0023_5959);
    chk("R7 no alarm yet", alarm_irq_o, 0);
    run_ticks(1);
    rd_chk("R2 msec wrap", 3'd5, 32'h0);
    rd_chk("R3 time wrap", 3'd0, 32'h0);
    rd_chk("R4 year wrap", 3'd1, 32'h0000_0101);
    chk("R7 alarm set", alarm_irq_o, 1);
    rd_chk("R7 status", 3'd4, 32'h1);
    chk("R8 512 Hz count", pcnt, 512);
    wr(3'd4, 32'h1);
    chk("R7 alarm clear", alarm_irq_o, 0);

    // R5 400-year rule, alarm disabled
    wr(3'd2, 32'h2900_0000);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h2000_0228);
    wr(3'd0, 32'h0023_5959);
    run_ticks(32768);
    rd_chk("R5 year 2000 leap", 3'd1, 32'h2000_0229);
    chk("R7 disabled alarm", alarm_irq_o, 0);

    // R5 100-year rule
    wr(3'd1, 32'h1900_0228);
    wr(3'd0, 32'h0023_5959);
    run_ticks(32768);
    rd_chk("R5 year 1900 common", 3'd1, 32'h1900_0301);
    rd_chk("R3 midnight", 3'd0, 32'h0);

    // R9 R10 R11 tamper
    wr(3'd3, 32'h40);
    wr(3'd1, 32'h2024_0715);
    wr(3'd0, 32'h0012_3456);
    @(negedge clk); tamper_i = 1'b1;
    @(negedge clk); tamper_i = 1'b0;
    chk("R9 flag", tamper_flag_o, 1);
    chk("R11 cut on", sram_cut_o, 1);
    rd_chk("R9 tamper time", 3'd6, 32'h0012_3456);
    rd_chk("R9 tamper date", 3'd7, 32'h2024_0715);
    rd_chk("R9 status", 3'd4, 32'h2);
    wr(3'd0, 32'h0001_0203);
    @(negedge clk); tamper_i = 1'b1;
    @(negedge clk); tamper_i = 1'b0;
    rd_chk("R10 one-shot time", 3'd6, 32'h0012_3456);
    rd_chk("R10 one-shot date", 3'd7, 32'h2024_0715);
    wr(3'd4, 32'h2);
    chk("R10 flag cleared", tamper_flag_o, 0);
    chk("R11 cut off", sram_cut_o, 0);
    wr(3'd3, 32'h0);
    @(negedge clk); tamper_i = 1'b1;
    @(negedge clk); tamper_i = 1'b0;
    chk("R9 flag again", tamper_flag_o, 1);
    chk("R11 cut disabled", sram_cut_o, 0);
    rd_chk("R9 new capture", 3'd6, 32'h0001_0203);
    finish_run();
  end

endmodule